// File: doc/BRIEF.md
# Receive-Side Malformed Request Filter

This block sits on the receive path of a packet link controller, between the link and the application. It accepts one request header per cycle with a valid strobe and checks it against two formation rules. The first rule covers memory requests: the start address and the length together must not carry the access past a 4 KB page boundary. This check is always built, even though the base protocol lists it as optional. The second rule covers messages: they must travel on traffic class 0.

A header that passes both rules goes to the application one cycle later with its fields unchanged. A header that breaks either rule is deleted silently and never reaches the application. In the same cycle where it would have appeared, the block raises a one-cycle uncorrectable fatal error pulse with a reason code. Headers can arrive back to back, and each slot is judged on its own, so a drop leaves no gap beyond its own slot.

Top module: `tlp_form_filter`

## Requirements
- R1: After reset, and while reset is held, `fwd_valid` and `err_valid` are 0 and `err_code` is 2'b00.
- R2: A header is a memory request when `hdr_dw0[28:25]` is 4'b0000. Its length is `hdr_dw0[9:0]` in doublewords, and a value of 0 means 1024. The request crosses a page when `hdr_addr[11:0] + 4*length > 4096`. A crossing request is dropped, and one cycle later `err_valid` is 1 with `err_code` 2'b01.
- R3: A memory request that ends exactly on the 4096-byte boundary is forwarded. This includes a length of 0 (1024 doublewords) at page offset 0.
- R4: A header is a message when `hdr_dw0[28:27]` is 2'b10. A message whose traffic class `hdr_dw0[22:20]` is not 0 is dropped, and one cycle later `err_valid` is 1 with `err_code` 2'b10.
- R5: A message on traffic class 0 is forwarded. A header that is neither a memory request nor a message is forwarded whatever its address, length and traffic class.
- R6: A header that passes is presented one cycle after acceptance with `fwd_valid` 1, and `fwd_dw0` and `fwd_addr` equal to the accepted values.
- R7: A dropped header never raises `fwd_valid`. `err_valid` lasts exactly one cycle for each drop, and `err_code` is 2'b00 whenever `err_valid` is 0.
- R8: Headers accepted on consecutive cycles are each judged on their own. Each result appears exactly one cycle after its own header, with no added bubble. A cycle without `hdr_valid` produces neither a forward nor an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | Header present this cycle |
| hdr_dw0 | input | 32 | First header doubleword (format/type, traffic class, length) |
| hdr_addr | input | ADDR_W (64) | Request address |
| fwd_valid | output | 1 | Forwarded header valid |
| fwd_dw0 | output | 32 | Forwarded first doubleword |
| fwd_addr | output | ADDR_W (64) | Forwarded address |
| err_valid | output | 1 | One-cycle fatal malformed-packet pulse |
| err_code | output | 2 | Reason: 01 page crossing, 10 message on nonzero class |

## Verification
The hardest cases to reach are the edges of the crossing sum. One is a request that ends exactly on byte 4096 and must pass. Another is the zero length field that stands for 1024 doublewords, which only passes at page offset 0. The directed stimulus picks the address offset and the length field so that the sum lands exactly at 4096 and at 4100. A second hard case is a burst that mixes pass and drop slots with no idle cycle between them, since a bug that leaks state from one slot into the next shows up only then. It is reached by driving headers on consecutive cycles and checking each result in the cycle that follows its own header.

// File: rtl/tlp_filt_pkg.sv
package tlp_filt_pkg;

   localparam int unsigned LEN_FIELD_W = 10;
   localparam int unsigned TC_W        = 3;

   typedef enum logic [1:0] {
      RSN_NONE  = 2'b00,
      RSN_CROSS = 2'b01,
      RSN_TC    = 2'b10
   } reason_e;

   typedef struct packed {
      logic                   is_mem;
      logic                   is_msg;
      logic [TC_W-1:0]        tc;
      logic [LEN_FIELD_W:0]   len_dw;
   } hdr_info_t;

endpackage

// File: rtl/tlp_hdr_decode.sv
module tlp_hdr_decode
   import tlp_filt_pkg::*;
(
   input  logic [3:0]             typ_hi,
   input  logic [TC_W-1:0]        tc_bits,
   input  logic [LEN_FIELD_W-1:0] len_bits,
   output hdr_info_t              info
);
   localparam logic [LEN_FIELD_W:0] LEN_MAX = {1'b1, {LEN_FIELD_W{1'b0}}};

   always_comb begin
      info.is_mem = (typ_hi == 4'b0000);
      info.is_msg = (typ_hi[3:2] == 2'b10);
      info.tc     = tc_bits;
      info.len_dw = (len_bits == '0) ? LEN_MAX : {1'b0, len_bits};
   end
endmodule

// File: rtl/tlp_cross_check.sv
module tlp_cross_check
   import tlp_filt_pkg::*;
#(
   parameter int unsigned PAGE_LOG2 = 12,
   parameter bit          ENABLE    = 1'b1
) (
   input  logic [PAGE_LOG2-1:0]   page_off,
   input  logic [LEN_FIELD_W:0]   len_dw,
   output logic                   crosses
);
   localparam int unsigned BYTES_W = LEN_FIELD_W + 3;
   localparam int unsigned SUM_W   = ((PAGE_LOG2 > BYTES_W) ? PAGE_LOG2 : BYTES_W) + 1;
   localparam logic [SUM_W-1:0] PAGE_BYTES = SUM_W'(1) << PAGE_LOG2;

   generate
      if (ENABLE) begin : g_check
         logic [SUM_W-1:0] end_byte;
         always_comb begin
            end_byte = SUM_W'(page_off) + SUM_W'({len_dw, 2'b00});
            crosses  = (end_byte > PAGE_BYTES);
         end
      end else begin : g_bypass
         logic unused_in;
         assign unused_in = ^{page_off, len_dw};
         assign crosses   = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/tlp_verdict.sv
module tlp_verdict
   import tlp_filt_pkg::*;
#(
   parameter bit TC_CHECK_EN = 1'b1
) (
   input  hdr_info_t info,
   input  logic      crosses,
   output logic      bad,
   output reason_e   reason
);
   logic tc_bad;

   generate
      if (TC_CHECK_EN) begin : g_tc
         assign tc_bad = info.is_msg && (info.tc != '0);
      end else begin : g_no_tc
         assign tc_bad = 1'b0;
      end
   endgenerate

   always_comb begin
      reason = RSN_NONE;
      if (info.is_mem && crosses) begin
         reason = RSN_CROSS;
      end else if (tc_bad) begin
         reason = RSN_TC;
      end
      bad = (reason != RSN_NONE);
   end
endmodule

// File: rtl/tlp_form_filter.sv
module tlp_form_filter
   import tlp_filt_pkg::*;
#(
   parameter int unsigned ADDR_W      = 64,
   parameter int unsigned PAGE_LOG2   = 12,
   parameter bit          CROSS_EN    = 1'b1,
   parameter bit          TC_CHECK_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hdr_valid,
   input  logic [31:0]       hdr_dw0,
   input  logic [ADDR_W-1:0] hdr_addr,
   output logic              fwd_valid,
   output logic [31:0]       fwd_dw0,
   output logic [ADDR_W-1:0] fwd_addr,
   output logic              err_valid,
   output logic [1:0]        err_code
);
   initial begin
      if (PAGE_LOG2 < 2 || PAGE_LOG2 > ADDR_W)
         $fatal(1, "tlp_form_filter: PAGE_LOG2 out of range");
      if (ADDR_W < 12)
         $fatal(1, "tlp_form_filter: ADDR_W too small");
   end

   hdr_info_t info;
   logic      crosses;
   logic      bad;
   reason_e   reason;

   tlp_hdr_decode u_dec (
      .typ_hi   (hdr_dw0[28:25]),
      .tc_bits  (hdr_dw0[22:20]),
      .len_bits (hdr_dw0[LEN_FIELD_W-1:0]),
      .info     (info)
   );

   tlp_cross_check #(.PAGE_LOG2(PAGE_LOG2), .ENABLE(CROSS_EN)) u_cross (
      .page_off (hdr_addr[PAGE_LOG2-1:0]),
      .len_dw   (info.len_dw),
      .crosses  (crosses)
   );

   tlp_verdict #(.TC_CHECK_EN(TC_CHECK_EN)) u_verdict (
      .info    (info),
      .crosses (crosses),
      .bad     (bad),
      .reason  (reason)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fwd_valid <= 1'b0;
         err_valid <= 1'b0;
         err_code  <= RSN_NONE;
      end else begin
         fwd_valid <= hdr_valid && !bad;
         err_valid <= hdr_valid && bad;
         err_code  <= hdr_valid ? reason : RSN_NONE;
      end
   end

   always_ff @(posedge clk) begin
      if (hdr_valid && !bad) begin
         fwd_dw0  <= hdr_dw0;
         fwd_addr <= hdr_addr;
      end
   end
endmodule

// File: rtl/tlp_form_filter_chk.sv
module tlp_form_filter_chk #(
   parameter int unsigned ADDR_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hdr_valid,
   input logic [31:0]       hdr_dw0,
   input logic [ADDR_W-1:0] hdr_addr,
   input logic              fwd_valid,
   input logic [31:0]       fwd_dw0,
   input logic [ADDR_W-1:0] fwd_addr,
   input logic              err_valid,
   input logic [1:0]        err_code
);
   AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !fwd_valid && !err_valid); // R1
   AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(fwd_valid && err_valid)); // R7
   AST_CODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !err_valid |-> err_code == 2'b00); // R7
   AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) err_valid |-> (err_code == 2'b01 || err_code == 2'b10)); // R2
   AST_MSG_TC_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid && hdr_dw0[28:27] == 2'b10 && hdr_dw0[22:20] != 3'd0 |=> err_valid && err_code == 2'b10 && !fwd_valid); // R4
   AST_OTHER_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid && hdr_dw0[28:25] != 4'b0000 && hdr_dw0[28:27] != 2'b10 |=> fwd_valid); // R5
   AST_FWD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid |=> !fwd_valid || (fwd_dw0 == $past(hdr_dw0) && fwd_addr == $past(hdr_addr))); // R6
   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      !hdr_valid |=> !fwd_valid && !err_valid); // R8
   AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid |=> fwd_valid || err_valid); // R8
endmodule

bind tlp_form_filter tlp_form_filter_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_dw0(hdr_dw0),
   .hdr_addr(hdr_addr), .fwd_valid(fwd_valid), .fwd_dw0(fwd_dw0),
   .fwd_addr(fwd_addr), .err_valid(err_valid), .err_code(err_code)
);

// File: tb/tlp_form_filter_bench.sv
module tlp_form_filter_bench;
   localparam int ADDR_W = 64;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              hdr_valid = 1'b0;
   logic [31:0]       hdr_dw0 = '0;
   logic [ADDR_W-1:0] hdr_addr = '0;
   logic              fwd_valid;
   logic [31:0]       fwd_dw0;
   logic [ADDR_W-1:0] fwd_addr;
   logic              err_valid;
   logic [1:0]        err_code;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   tlp_form_filter u_tlp_form_filter (
      .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_dw0(hdr_dw0),
      .hdr_addr(hdr_addr), .fwd_valid(fwd_valid), .fwd_dw0(fwd_dw0),
      .fwd_addr(fwd_addr), .err_valid(err_valid), .err_code(err_code)
   );

   function automatic logic [31:0] mk(input logic [2:0] fmt, input logic [4:0] typ,
                                      input logic [2:0] tc, input logic [9:0] len);
      return {fmt, typ, 1'b0, tc, 10'b0, len};
   endfunction

   // expected reason: 0 pass, 1 page crossing, 2 message on nonzero class
   function automatic logic [1:0] expect_code(input logic [31:0] dw0, input logic [ADDR_W-1:0] a);
      int len;
      len = (dw0[9:0] == 10'd0) ? 1024 : int'(dw0[9:0]);
      if (dw0[28:25] == 4'b0000 && (int'(a[11:0]) + 4 * len) > 4096) return 2'b01;
      if (dw0[28:27] == 2'b10 && dw0[22:20] != 3'd0) return 2'b10;
      return 2'b00;
   endfunction

   task automatic check(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // drive at a negedge, check the result at the following negedge
   task automatic send(input string req, input logic [31:0] dw0, input logic [ADDR_W-1:0] a);
      logic [1:0] ec;
      ec = expect_code(dw0, a);
      hdr_valid = 1'b1; hdr_dw0 = dw0; hdr_addr = a;
      @(negedge clk);
      check(req, "fwd_valid", 128'(fwd_valid), 128'(ec == 2'b00));
      check(req, "err_valid", 128'(err_valid), 128'(ec != 2'b00));
      check(req, "err_code", 128'(err_code), 128'(ec));
      if (ec == 2'b00) begin
         check(req, "fwd_dw0", 128'(fwd_dw0), 128'(dw0));
         check(req, "fwd_addr", 128'(fwd_addr), 128'(a));
      end
   endtask

   task automatic idle(input string req);
      hdr_valid = 1'b0; hdr_dw0 = 32'hFFFF_FFFF; hdr_addr = '1;
      @(negedge clk);
      check(req, "idle fwd_valid", 128'(fwd_valid), 128'(0));
      check(req, "idle err_valid", 128'(err_valid), 128'(0));
      check(req, "idle err_code", 128'(err_code), 128'(0));
   endtask

   task automatic t_reset;
      check("R1", "reset fwd_valid", 128'(fwd_valid), 128'(0));
      check("R1", "reset err_valid", 128'(err_valid), 128'(0));
      check("R1", "reset err_code", 128'(err_code), 128'(0));
   endtask

   task automatic t_cross;       // R2
      send("R2", mk(3'b011, 5'b00000, 3'd0, 10'd2), 64'h1_0000_0FFC);
      send("R2", mk(3'b000, 5'b00000, 3'd0, 10'd0), 64'h4);
      send("R2", mk(3'b000, 5'b00001, 3'd0, 10'd16), 64'hFC8);
      idle("R7");
   endtask

   task automatic t_fit;         // R3
      send("R3", mk(3'b011, 5'b00000, 3'd0, 10'd1), 64'hABCD_0FFC);
      send("R3", mk(3'b010, 5'b00000, 3'd0, 10'd0), 64'h2000);
      send("R3", mk(3'b000, 5'b00000, 3'd0, 10'd16), 64'hFC0);
   endtask

   task automatic t_msg;         // R4 R5
      send("R4", mk(3'b001, 5'b10000, 3'd3, 10'd0), 64'h0);
      send("R4", mk(3'b011, 5'b10100, 3'd7, 10'd1), 64'h0);
      send("R5", mk(3'b001, 5'b10000, 3'd0, 10'd0), 64'hFFF);
      // completion, crossing address and nonzero class: not subject to either rule
      send("R5", mk(3'b010, 5'b01010, 3'd5, 10'd512), 64'hF00);
      send("R5", mk(3'b000, 5'b00100, 3'd2, 10'd0), 64'hFFC);
      idle("R7");
   endtask

   task automatic t_burst;       // R6 R8
      send("R8", mk(3'b010, 5'b00000, 3'd1, 10'd4), 64'h1234_5000);
      send("R8", mk(3'b011, 5'b00000, 3'd0, 10'd3), 64'h0FF8);
      send("R8", mk(3'b001, 5'b10011, 3'd4, 10'd0), 64'h0);
      send("R6", mk(3'b011, 5'b00000, 3'd0, 10'd8), 64'hDEAD_BEEF_0000_0100);
      idle("R8");
      idle("R7");
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_cross();
      t_fit();
      t_msg();
      t_burst();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule